// File: doc/BRIEF.md
# Clock Frequency Monitor with Key-Protected Control

This block checks a fast monitored clock against a slower reference clock. Over a fixed window of reference cycles it counts the edges of the monitored clock. The monitored domain hands the count back through a toggle handshake, and the block then compares it with a programmed inclusive window [min, max]. A count outside that window starts a reset-request pulse. A monitored clock that stops altogether never answers the handshake, so it also starts a reset request.

Two pairs of limits are held, one for PLL-off and one for PLL-on operation, and the `pll_on` input picks the pair in use. Detection is switched on and off through an enable register. A key register guards writes to the enable register. Detection runs only in the normal and idle power modes. The control and limit registers are cleared only by the external reset. An internal reset restarts the measurement and leaves the registers as they were.

Top module: `freq_watch`

## Requirements
- R1: While the key holds 0xF9, writing 0xE4 to the enable register (address 1) turns detection on and writing 0x00 turns it off. Writing any other value leaves the enable register unchanged.
- R2: Writing 0xF9 to the key register (address 0) unlocks the enable register. Writing any other value to the key, for example 0x06, locks it. A write to the enable register while it is locked has no effect.
- R3: Any register can be read on `rd_data` through `rd_addr`, whatever the key holds. The addresses are: 0 key, 1 enable, 2 PLL-off min, 3 PLL-off max, 4 PLL-on min, 5 PLL-on max. The 8-bit registers read back zero-extended.
- R4: External reset (`ext_rst_n` low) sets the key to 0x06, the enable register to 0x00, both min limits to 0 and both max limits to all ones.
- R5: Internal reset (`int_rst_n` low) keeps the contents of every register and clears the measurement and request state.
- R6: Detection is active only when the enable register holds 0xE4 and `pwr_mode` is normal (0) or idle (1). In stop (2) or warm-up (3) no request starts, and detection resumes when the mode returns to normal or idle.
- R7: `pll_on` = 0 selects the limits at addresses 2 and 3. `pll_on` = 1 selects the limits at addresses 4 and 5.
- R8: The count of monitored-clock rising edges over each window of WIN reference cycles is compared with the selected [min, max], bounds included. A count outside the window requests a reset. The first window after detection becomes active is not judged.
- R9: If a window ends while the previous count has still not come back from the monitored domain, the monitored clock is treated as stalled and a reset is requested.
- R10: `det_rst_req` is a registered pulse that stays high for exactly PULSE reference cycles. While it is high no new request can start, and the measurement window then begins again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; registers and decision logic |
| mon_clk | input | 1 | Monitored high-frequency clock |
| ext_rst_n | input | 1 | External reset, active low; clears the registers |
| int_rst_n | input | 1 | Internal reset, active low; clears the measurement only |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Read data for rd_addr |
| pll_on | input | 1 | Selects the PLL-on limit pair |
| pwr_mode | input | 2 | 0 normal, 1 idle, 2 stop, 3 warm-up |
| det_rst_req | output | 1 | Reset-request pulse |

## Verification
The assertions check on every cycle that the enable register only ever holds one of its two codes and changes only after an unlocked write to its address. They also check that no request starts while detection is inactive, that a request pulse lasts longer than one cycle, and that an acknowledge never arrives without a request outstanding. Only the bench's scenarios can show the frequency judgement itself. It runs monitored clocks at several rates against limit pairs that contain or exclude the expected count, a stopped clock, limit-pair selection by `pll_on`, the exact pulse length, and the registers surviving an internal reset but not an external one.

// File: rtl/fw_pkg.sv
package fw_pkg;
    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_IDLE   = 2'd1,
        PM_STOP   = 2'd2,
        PM_WARM   = 2'd3
    } pmode_e;

    localparam logic [7:0] KEY_OPEN = 8'hF9;
    localparam logic [7:0] KEY_SHUT = 8'h06;
    localparam logic [7:0] EN_ON    = 8'hE4;
    localparam logic [7:0] EN_OFF   = 8'h00;

    localparam logic [2:0] A_KEY    = 3'd0;
    localparam logic [2:0] A_EN     = 3'd1;
    localparam logic [2:0] A_OFFMIN = 3'd2;
    localparam logic [2:0] A_OFFMAX = 3'd3;
    localparam logic [2:0] A_ONMIN  = 3'd4;
    localparam logic [2:0] A_ONMAX  = 3'd5;
endpackage

// File: rtl/fw_regs.sv
module fw_regs
    import fw_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          ext_rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          en_on,
    output logic [DW-1:0] off_min,
    output logic [DW-1:0] off_max,
    output logic [DW-1:0] on_min,
    output logic [DW-1:0] on_max
);
    typedef struct packed {
        logic [7:0]    key;
        logic [7:0]    en;
        logic [DW-1:0] offmin;
        logic [DW-1:0] offmax;
        logic [DW-1:0] onmin;
        logic [DW-1:0] onmax;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                A_KEY: r_d.key = wr_data[7:0];
                A_EN: begin
                    if (r_q.key == KEY_OPEN &&
                        (wr_data[7:0] == EN_ON || wr_data[7:0] == EN_OFF))
                        r_d.en = wr_data[7:0];
                end
                A_OFFMIN: r_d.offmin = wr_data;
                A_OFFMAX: r_d.offmax = wr_data;
                A_ONMIN:  r_d.onmin  = wr_data;
                A_ONMAX:  r_d.onmax  = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            r_q.key    <= KEY_SHUT;
            r_q.en     <= EN_OFF;
            r_q.offmin <= '0;
            r_q.offmax <= '1;
            r_q.onmin  <= '0;
            r_q.onmax  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (rd_addr)
            A_KEY:    rd_data = {{(DW-8){1'b0}}, r_q.key};
            A_EN:     rd_data = {{(DW-8){1'b0}}, r_q.en};
            A_OFFMIN: rd_data = r_q.offmin;
            A_OFFMAX: rd_data = r_q.offmax;
            A_ONMIN:  rd_data = r_q.onmin;
            A_ONMAX:  rd_data = r_q.onmax;
            default:  rd_data = '0;
        endcase
    end

    assign en_on   = (r_q.en == EN_ON);
    assign off_min = r_q.offmin;
    assign off_max = r_q.offmax;
    assign on_min  = r_q.onmin;
    assign on_max  = r_q.onmax;

    // R1
    enable_code_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (r_q.en == EN_ON || r_q.en == EN_OFF));

    // R2
    enable_hold_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        !$stable(r_q.en) |-> $past(wr_en && wr_addr == A_EN && r_q.key == KEY_OPEN));
endmodule

// File: rtl/fw_meas.sv
module fw_meas #(
    parameter int DW = 16
) (
    input  logic          mon_clk,
    input  logic          rst_n,
    input  logic          req_tgl,
    output logic [DW-1:0] hold,
    output logic          ack_tgl
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] hold;
        logic [1:0]    sync;
        logic          seen;
        logic          ack;
    } meas_t;

    meas_t m_d, m_q;

    always_comb begin
        m_d      = m_q;
        m_d.sync = {m_q.sync[0], req_tgl};
        if (m_q.sync[1] != m_q.seen) begin
            m_d.hold = m_q.cnt;
            m_d.cnt  = DW'(1);
            m_d.seen = m_q.sync[1];
            m_d.ack  = ~m_q.ack;
        end else if (!(&m_q.cnt)) begin
            m_d.cnt = m_q.cnt + DW'(1);
        end
    end

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign hold    = m_q.hold;
    assign ack_tgl = m_q.ack;
endmodule

// File: rtl/fw_judge.sv
module fw_judge #(
    parameter int DW    = 16,
    parameter int WIN   = 64,
    parameter int PULSE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] hold,
    input  logic          ack_tgl,
    output logic          req_tgl,
    output logic          fault_o
);
    localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int PW = $clog2(PULSE + 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN - 1);

    typedef struct packed {
        logic [WW-1:0] win;
        logic          req;
        logic [1:0]    async;
        logic          aseen;
        logic          primed;
        logic          armed;
        logic [PW-1:0] pcnt;
    } judge_t;

    judge_t j_d, j_q;
    logic arrived, busy, fault;

    always_comb begin
        j_d       = j_q;
        fault     = 1'b0;
        j_d.async = {j_q.async[0], ack_tgl};
        arrived   = (j_q.async[1] != j_q.aseen);
        busy      = (j_q.req != j_q.aseen);
        if (arrived) j_d.aseen = j_q.async[1];

        if (j_q.pcnt != '0) begin
            j_d.pcnt   = j_q.pcnt - PW'(1);
            j_d.win    = '0;
            j_d.primed = 1'b0;
            j_d.armed  = 1'b0;
        end else if (!active) begin
            j_d.win    = '0;
            j_d.primed = 1'b0;
            j_d.armed  = 1'b0;
        end else begin
            if (arrived && j_q.armed) begin
                j_d.armed = 1'b0;
                if (hold < lo || hold > hi) fault = 1'b1;
            end
            if (j_q.win == WIN_LAST) begin
                j_d.win = '0;
                if (busy && !arrived) begin
                    fault = 1'b1;
                end else begin
                    j_d.req    = ~j_q.req;
                    j_d.armed  = j_q.primed;
                    j_d.primed = 1'b1;
                end
            end else begin
                j_d.win = j_q.win + WW'(1);
            end
            if (fault) begin
                j_d.pcnt   = PW'(PULSE);
                j_d.win    = '0;
                j_d.primed = 1'b0;
                j_d.armed  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) j_q <= '0;
        else        j_q <= j_d;
    end

    assign req_tgl = j_q.req;
    assign fault_o = (j_q.pcnt != '0);

    // R8
    ack_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (j_q.async[1] != j_q.aseen) |-> (j_q.req != j_q.aseen));

    // R6
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !fault_o) |=> !fault_o);

    // R10
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |=> fault_o);
endmodule

// File: rtl/freq_watch.sv
module freq_watch
    import fw_pkg::*;
#(
    parameter int DW    = 16,
    parameter int WIN   = 64,
    parameter int PULSE = 4
) (
    input  logic          ref_clk,
    input  logic          mon_clk,
    input  logic          ext_rst_n,
    input  logic          int_rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          pll_on,
    input  logic [1:0]    pwr_mode,
    output logic          det_rst_req
);
    logic          en_on, active, meas_rst_n, req_tgl, ack_tgl;
    logic [DW-1:0] off_min, off_max, on_min, on_max, lo, hi, hold;

    assign meas_rst_n = ext_rst_n & int_rst_n;

    fw_regs #(.DW(DW)) u_regs (
        .clk(ref_clk), .ext_rst_n(ext_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .en_on(en_on),
        .off_min(off_min), .off_max(off_max), .on_min(on_min), .on_max(on_max)
    );

    assign active = en_on && (pwr_mode == PM_NORMAL || pwr_mode == PM_IDLE);
    assign lo     = pll_on ? on_min : off_min;
    assign hi     = pll_on ? on_max : off_max;

    fw_meas #(.DW(DW)) u_meas (
        .mon_clk(mon_clk), .rst_n(meas_rst_n), .req_tgl(req_tgl),
        .hold(hold), .ack_tgl(ack_tgl)
    );

    fw_judge #(.DW(DW), .WIN(WIN), .PULSE(PULSE)) u_judge (
        .clk(ref_clk), .rst_n(meas_rst_n), .active(active),
        .lo(lo), .hi(hi), .hold(hold), .ack_tgl(ack_tgl),
        .req_tgl(req_tgl), .fault_o(det_rst_req)
    );
endmodule

// File: tb/freq_watch_tb.sv
`timescale 1ns/1ps
module freq_watch_tb;
    localparam int DW = 16, WIN = 64, PULSE = 4;

    logic ref_clk = 0, mon_clk = 0, ext_rst_n = 0, int_rst_n = 1;
    logic wr_en = 0, pll_on = 0;
    logic [2:0] wr_addr = 0, rd_addr = 0;
    logic [DW-1:0] wr_data = 0, rd_data;
    logic [1:0] pwr_mode = 2'd0;
    logic det_rst_req;

    int n_chk = 0, n_bad = 0, npulse = 0, last_w = 0, run_w = 0;
    bit prev_det = 0, mon_run = 1, done = 0;
    int half_ps = 1000;

    freq_watch #(.DW(DW), .WIN(WIN), .PULSE(PULSE)) u_dut (.*);

    always #2 ref_clk = ~ref_clk;
    always begin
        if (mon_run) begin #(real'(half_ps) / 1000.0); mon_clk = ~mon_clk; end
        else #1;
    end

    always @(negedge ref_clk) begin
        if (det_rst_req && !prev_det) npulse++;
        if (det_rst_req) run_w++;
        else if (prev_det) begin last_w = run_w; run_w = 0; end
        prev_det = det_rst_req;
    end

    function automatic int exp_cnt(int h);
        return (WIN * 4000) / (2 * h);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, int d);
        @(negedge ref_clk);
        wr_en = 1; wr_addr = a; wr_data = DW'(d);
        @(negedge ref_clk);
        wr_en = 0;
    endtask

    task automatic rd(logic [2:0] a, output int v);
        rd_addr = a; #0.5; v = int'(rd_data);
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic set_lim(bit pll, int lo, int hi);
        wr(pll ? 3'd4 : 3'd2, lo);
        wr(pll ? 3'd5 : 3'd3, hi);
    endtask

    task automatic flush_then_run(logic [1:0] mode);
        pwr_mode = 2'd2; cyc(20); npulse = 0;
        pwr_mode = mode;
    endtask

    initial begin
        int v, e, lo, hi, r;
        bit bad, pll;
        void'($urandom(7));
        cyc(3); ext_rst_n = 1; cyc(2);

        rd(3'd0, v); chk(v == 8'h06, "R4 key reset", v, 8'h06);
        rd(3'd1, v); chk(v == 8'h00, "R4 enable reset", v, 0);
        rd(3'd2, v); chk(v == 0, "R4 min reset", v, 0);
        rd(3'd5, v); chk(v == 16'hFFFF, "R4 max reset", v, 16'hFFFF);

        wr(3'd1, 8'hE4); rd(3'd1, v); chk(v == 0, "R2 locked write ignored", v, 0);
        wr(3'd0, 8'hF9);
        wr(3'd1, 8'h55); rd(3'd1, v); chk(v == 0, "R1 other code ignored", v, 0);
        wr(3'd1, 8'hE4); rd(3'd1, v); chk(v == 8'hE4, "R1 enable on", v, 8'hE4);
        wr(3'd0, 8'h06);
        rd(3'd1, v); chk(v == 8'hE4, "R3 enable readable locked", v, 8'hE4);
        wr(3'd1, 8'h00); rd(3'd1, v); chk(v == 8'hE4, "R2 relocked write ignored", v, 8'hE4);

        // R8 in-range count, PLL-off pair
        half_ps = 1000; e = exp_cnt(half_ps);
        set_lim(0, e - 6, e + 6);
        flush_then_run(2'd0); cyc(10 * WIN);
        chk(npulse == 0, "R8 in range no request", npulse, 0);

        // R7 on-pair bad, off-pair good, pll_on selects
        set_lim(1, e + 20, e + 40);
        pll_on = 1; flush_then_run(2'd0); cyc(10 * WIN);
        chk(npulse > 0, "R7 pll_on picks on-pair", npulse, 1);
        chk(last_w == PULSE, "R10 pulse width", last_w, PULSE);
        // R6 stop and warm-up suppress
        pwr_mode = 2'd2; cyc(20); npulse = 0; cyc(10 * WIN);
        chk(npulse == 0, "R6 stop quiet", npulse, 0);
        pwr_mode = 2'd3; cyc(10 * WIN);
        chk(npulse == 0, "R6 warm-up quiet", npulse, 0);
        pwr_mode = 2'd1; cyc(10 * WIN);
        chk(npulse > 0, "R6 idle resumes", npulse, 1);
        pll_on = 0; flush_then_run(2'd0); cyc(10 * WIN);
        chk(npulse == 0, "R7 pll_on low picks off-pair", npulse, 0);

        // R5 internal reset keeps registers
        @(negedge ref_clk); int_rst_n = 0; cyc(3); int_rst_n = 1; cyc(2);
        rd(3'd1, v); chk(v == 8'hE4, "R5 enable kept", v, 8'hE4);
        rd(3'd4, v); chk(v == e + 20, "R5 limit kept", v, e + 20);

        // R9 stalled monitored clock
        flush_then_run(2'd0); mon_run = 0; cyc(10 * WIN);
        chk(npulse > 0, "R9 stall requests", npulse, 1);
        chk(last_w == PULSE, "R10 stall pulse width", last_w, PULSE);
        mon_run = 1;

        // R8 random trials
        for (int t = 0; t < 8; t++) begin
            r = int'($urandom_range(3, 0));
            half_ps = (r == 0) ? 1000 : (r == 1) ? 1250 : (r == 2) ? 1600 : 2000;
            e = exp_cnt(half_ps);
            bad = 1'($urandom_range(1, 0));
            pll = 1'($urandom_range(1, 0));
            r = int'($urandom_range(7, 0));
            if (!bad) begin lo = e - 4 - r; hi = e + 4 + r; end
            else if (r[0]) begin lo = e + 4 + r; hi = lo + 20; end
            else begin hi = e - 4 - r; lo = hi - 20; end
            pwr_mode = 2'd2;
            set_lim(pll, lo, hi);
            set_lim(!pll, bad ? e - 8 : e + 8, bad ? e + 8 : e + 30);
            pll_on = pll;
            flush_then_run(2'd0); cyc(10 * WIN);
            chk((npulse > 0) == bad, "R8 random window", npulse, int'(bad));
        end

        // R1 disable code stops detection
        half_ps = 1000; e = exp_cnt(half_ps);
        set_lim(0, e + 20, e + 40); pll_on = 0;
        wr(3'd0, 8'hF9); wr(3'd1, 8'h00); wr(3'd0, 8'h06);
        flush_then_run(2'd0); cyc(10 * WIN);
        chk(npulse == 0, "R1 disabled quiet", npulse, 0);

        // R4 external reset clears
        @(negedge ref_clk); ext_rst_n = 0; cyc(2); ext_rst_n = 1; cyc(2);
        rd(3'd2, v); chk(v == 0, "R4 limit cleared", v, 0);
        rd(3'd0, v); chk(v == 8'h06, "R4 key cleared", v, 8'h06);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule